// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block produces the square-wave carrier that an infrared transmitter modulates onto its light source. The high time and the low time of each carrier period are programmed separately as counts of a modulation tick. The tick comes from one of four sources: every system clock, or one of three tick enables generated elsewhere (crystal clock divided by three, 1 µs, 10 µs). Converting a carrier frequency and a duty cycle into tick counts is left to software or to a neighbouring block. For example, with the 1 µs source, a word carrying 12 in both halves gives 13 high and 13 low ticks. That is a 38.5 kHz carrier at 50 percent duty, the usual 38 kHz setting.

Software clears the enable and sets the initial-level bit to park the output. It then programs the count word and the source, and sets the enable again. Each carrier period ends with a single-cycle strobe that a downstream envelope timer can use as its timebase. The count word may be rewritten while the carrier runs. The new counts take effect only at the next period boundary, so no period is ever cut short or stretched.

Top module: `irc_carrier_gen`

## Requirements
- R1: The count word holds (high ticks − 1) in bits [31:16] and (low ticks − 1) in bits [15:0]; a field of 0 means one tick.
- R2: The source select chooses the tick: 0 means every system clock, 1 means tick_xtal3_i, 2 means tick_1us_i, 3 means tick_10us_i. Ticks of unselected sources do not advance the carrier.
- R3: While enabled, each period starts with carrier_o high for the high tick count, followed by carrier_o low for the low tick count. In the first cycle after enable is sampled high, the counts are loaded from the word and the output becomes high.
- R4: period_end_o is high for exactly one system clock. That clock is the one whose tick ends the low phase. The strobe is never high at any other time.
- R5: A count word changed while the carrier runs takes effect only at the start of the next period. The period in progress completes with the old counts.
- R6: While the enable is low, carrier_o equals init_high_i and period_end_o is low.
- R7: When the enable is cleared and set again, the carrier restarts with a complete high phase from the current count word.
- R8: After reset with the enable low, period_end_o is low and carrier_o follows init_high_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Modulation tick source select |
| tick_xtal3_i | input | 1 | Tick enable, crystal clock divided by 3 |
| tick_1us_i | input | 1 | Tick enable, 1 µs |
| tick_10us_i | input | 1 | Tick enable, 10 µs |
| count_word_i | input | 32 | High ticks − 1 in [31:16], low ticks − 1 in [15:0] |
| enable_i | input | 1 | Generator enable |
| init_high_i | input | 1 | Output level while disabled |
| carrier_o | output | 1 | Carrier waveform |
| period_end_o | output | 1 | Strobe on the last tick of each period |

## Verification
A wrong phase count or a wrong phase state shows at carrier_o within one tick of the faulty edge. A stale or early count reload shows one period later, as a period of the wrong length. The bench runs its own tick-level model of the period position and compares carrier_o and period_end_o with it on every system clock. Any drift is therefore reported in the first cycle where the waveform differs. Failures of source selection or of restart after disable show up within a few ticks, because random tick patterns are driven on all three alternate sources at the same time.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned WORD_W = 2 * CNT_W;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_XTAL3 = 2'd1,
    SRC_1US   = 2'd2,
    SRC_10US  = 2'd3
  } src_sel_e;

  typedef enum logic {
    PH_HIGH = 1'b1,
    PH_LOW  = 1'b0
  } phase_e;
endpackage

// File: rtl/irc_tick_sel.sv
module irc_tick_sel
  import irc_pkg::*;
(
  input  logic [1:0] src_sel_i,
  input  logic       tick_xtal3_i,
  input  logic       tick_1us_i,
  input  logic       tick_10us_i,
  output logic       tick_o
);
  always_comb begin
    unique case (src_sel_e'(src_sel_i))
      SRC_SYS:   tick_o = 1'b1;
      SRC_XTAL3: tick_o = tick_xtal3_i;
      SRC_1US:   tick_o = tick_1us_i;
      SRC_10US:  tick_o = tick_10us_i;
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irc_phase_ctr.sv
module irc_phase_ctr
  import irc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] hi_lim_i,
  input  logic [CW-1:0] lo_lim_i,
  output logic          run_o,
  output logic          high_o,
  output logic          wrap_o
);
  logic          run_q;
  phase_e        phase_q;
  logic [CW-1:0] cnt_q, hi_q, lo_q;
  logic          last_hi, last_lo;

  assign last_hi = (phase_q == PH_HIGH) && (cnt_q == hi_q);
  assign last_lo = (phase_q == PH_LOW)  && (cnt_q == lo_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (!en_i) begin
      run_q   <= 1'b0;
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
    end else if (!run_q) begin
      // first enabled cycle: latch limits, start high phase
      run_q   <= 1'b1;
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      hi_q    <= hi_lim_i;
      lo_q    <= lo_lim_i;
    end else if (tick_i) begin
      if (last_hi) begin
        phase_q <= PH_LOW;
        cnt_q   <= '0;
      end else if (last_lo) begin
        // period boundary: only place new limits are taken
        phase_q <= PH_HIGH;
        cnt_q   <= '0;
        hi_q    <= hi_lim_i;
        lo_q    <= lo_lim_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign high_o = (phase_q == PH_HIGH);
  assign wrap_o = run_q && en_i && tick_i && last_lo;
endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
  import irc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        src_sel_i,
  input  logic              tick_xtal3_i,
  input  logic              tick_1us_i,
  input  logic              tick_10us_i,
  input  logic [WORD_W-1:0] count_word_i,
  input  logic              enable_i,
  input  logic              init_high_i,
  output logic              carrier_o,
  output logic              period_end_o
);
  logic tick, run, high;

  irc_tick_sel u_tick_sel (
    .src_sel_i    (src_sel_i),
    .tick_xtal3_i (tick_xtal3_i),
    .tick_1us_i   (tick_1us_i),
    .tick_10us_i  (tick_10us_i),
    .tick_o       (tick)
  );

  irc_phase_ctr #(.CW(CNT_W)) u_phase_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .tick_i   (tick),
    .hi_lim_i (count_word_i[WORD_W-1:CNT_W]),
    .lo_lim_i (count_word_i[CNT_W-1:0]),
    .run_o    (run),
    .high_o   (high),
    .wrap_o   (period_end_o)
  );

  assign carrier_o = run ? high : init_high_i;
endmodule

// File: rtl/irc_carrier_gen_chk.sv
module irc_carrier_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] src_sel_i,
  input logic       tick_xtal3_i,
  input logic       tick_1us_i,
  input logic       tick_10us_i,
  input logic       enable_i,
  input logic       init_high_i,
  input logic       carrier_o,
  input logic       period_end_o
);
  logic en_d;
  logic sel_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_d <= 1'b0;
    else         en_d <= enable_i;
  end

  assign sel_tick = (src_sel_i == 2'd0) ||
                    (src_sel_i == 2'd1 && tick_xtal3_i) ||
                    (src_sel_i == 2'd2 && tick_1us_i) ||
                    (src_sel_i == 2'd3 && tick_10us_i);

  // R4
  strobe_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> (enable_i && !carrier_o));

  // R2
  strobe_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> sel_tick);

  // R3
  start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !en_d) |=> (carrier_o || !enable_i));

  // R4
  strobe_then_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_o && enable_i) |=> (carrier_o || !enable_i));

  // R6
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ((carrier_o == init_high_i) && !period_end_o));
endmodule

bind irc_carrier_gen irc_carrier_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_sel_i    (src_sel_i),
  .tick_xtal3_i (tick_xtal3_i),
  .tick_1us_i   (tick_1us_i),
  .tick_10us_i  (tick_10us_i),
  .enable_i     (enable_i),
  .init_high_i  (init_high_i),
  .carrier_o    (carrier_o),
  .period_end_o (period_end_o)
);

// File: tb/irc_carrier_gen_tb_top.sv
module irc_carrier_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  src_sel_i = 2'd0;
  logic        tick_xtal3_i = 1'b0, tick_1us_i = 1'b0, tick_10us_i = 1'b0;
  logic [31:0] count_word_i = 32'h0;
  logic        enable_i = 1'b0;
  logic        init_high_i = 1'b0;
  logic        carrier_o, period_end_o;

  int checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R8";
  bit tick_rand = 1'b0;

  // bench model state (tick domain)
  bit m_run = 1'b0;
  int m_h = 1, m_l = 1, m_pos = 0;

  always #2.5 clk_i = ~clk_i;

  irc_carrier_gen dut_i (.*);

  function automatic bit sel_tick(input logic [1:0] s, input logic x, input logic u, input logic t);
    case (s)
      2'd0: return 1'b1;
      2'd1: return x;
      2'd2: return u;
      default: return t;
    endcase
  endfunction

  function automatic logic [31:0] mk_word(input int h, input int l);
    return {16'(h - 1), 16'(l - 1)}; // R1 field layout
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // model update at the edge the DUT samples
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 1'b0; m_pos = 0;
    end else if (!enable_i) begin
      m_run = 1'b0; m_pos = 0;
    end else if (!m_run) begin
      m_run = 1'b1; m_pos = 0;
      m_h = int'(count_word_i[31:16]) + 1;
      m_l = int'(count_word_i[15:0]) + 1;
    end else if (sel_tick(src_sel_i, tick_xtal3_i, tick_1us_i, tick_10us_i)) begin
      m_pos++;
      if (m_pos == m_h + m_l) begin
        m_pos = 0;
        m_h = int'(count_word_i[31:16]) + 1;
        m_l = int'(count_word_i[15:0]) + 1;
      end
    end
  end

  // compare at the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit tk, exp_c, exp_s;
      tk    = sel_tick(src_sel_i, tick_xtal3_i, tick_1us_i, tick_10us_i);
      exp_c = m_run ? (m_pos < m_h) : init_high_i;
      exp_s = m_run && enable_i && tk && (m_pos == m_h + m_l - 1);
      check(m_run ? {"R3 carrier ", cur_tag} : {"R6 idle carrier ", cur_tag}, carrier_o, exp_c);
      check({"R4 strobe ", cur_tag}, period_end_o, exp_s);
    end
  end

  // tick stimulus
  initial begin
    forever begin
      @(posedge clk_i); #1;
      tick_xtal3_i = tick_rand ? ($urandom % 3 == 0) : 1'b1;
      tick_1us_i   = tick_rand ? ($urandom % 4 == 0) : 1'b0;
      tick_10us_i  = tick_rand ? ($urandom % 5 == 0) : 1'b1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic restart(input logic [1:0] s, input logic [31:0] w, input int n);
    enable_i = 1'b0; step(2);
    src_sel_i = s; count_word_i = w;
    enable_i = 1'b1; step(n);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    step(3);
    rst_ni = 1'b1;
    // R8: reset state follows init level
    init_high_i = 1'b1; step(1);
    @(negedge clk_i);
    check("R8 reset carrier", carrier_o, 1'b1);
    check("R8 reset strobe", period_end_o, 1'b0);
    step(1); init_high_i = 1'b0; step(2);
    @(negedge clk_i);
    check("R8 reset carrier low", carrier_o, 1'b0);
    step(1);

    // R1 R3: system clock source, directed counts
    cur_tag = "R1"; restart(2'd0, mk_word(3, 2), 40);
    cur_tag = "R1 min"; restart(2'd0, mk_word(1, 1), 20);
    cur_tag = "R3 asym"; restart(2'd0, mk_word(1, 6), 30);

    // R2: each alternate source with random ticks on all sources
    tick_rand = 1'b1;
    for (int s = 1; s < 4; s++) begin
      cur_tag = "R2";
      restart(2'(s), mk_word(2 + s, 4 - s), 150);
    end
    // R2: unselected pulses while selected source idle high fixed ticks
    tick_rand = 1'b0;
    cur_tag = "R2 unsel"; restart(2'd2, mk_word(2, 2), 40);
    check("R2 no tick, carrier stays high", carrier_o, 1'b1);

    // R5: rewrite the word mid-run at random points
    tick_rand = 1'b1;
    cur_tag = "R5"; restart(2'd0, mk_word(4, 3), 5);
    for (int k = 0; k < 20; k++) begin
      count_word_i = mk_word(1 + $urandom % 6, 1 + $urandom % 6);
      step(1 + $urandom % 11);
    end

    // R6 R7: disable mid-run, toggle init, re-enable
    for (int k = 0; k < 10; k++) begin
      cur_tag = "R6";
      enable_i = 1'b0; step(1);
      init_high_i = ~init_high_i; step(2 + $urandom % 3);
      cur_tag = "R7";
      src_sel_i = 2'($urandom % 4);
      count_word_i = mk_word(1 + $urandom % 5, 1 + $urandom % 5);
      enable_i = 1'b1; step(5 + $urandom % 40);
    end

    // random mix
    cur_tag = "R3 rand";
    for (int k = 0; k < 40; k++) begin
      restart(2'($urandom % 4), mk_word(1 + $urandom % 9, 1 + $urandom % 9), 20 + $urandom % 100);
      if ($urandom % 2) count_word_i = mk_word(1 + $urandom % 9, 1 + $urandom % 9);
      step(10 + $urandom % 50);
    end

    enable_i = 1'b0; step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule